// File: doc/BRIEF.md
# Codec Register Access Sequencer

This block carries register reads and writes from a host to an external codec over a framed serial link. Each frame opens with one command slot. The host loads a control word into the block. The word holds a codec register address, a write flag and a 16-bit data value. The block places that word in the command slot of the next frame and keeps it there for the length of the slot. At the end of the slot it samples the codec's reply, which is an echoed address and 16 bits of data.

A reply counts as good only when the echoed address equals the address that was sent. When a reply is bad, the block sends the same command again in the following frame. It makes at most `MAX_TRIES` attempts in all. When the command finishes, the block does three things in the same clock edge: it updates the status registers, it sets an error flag when every attempt failed, and it raises a completion flag. The completion flag stays high until the host clears it.

A read is a command with the write flag clear; its data field is ignored. A register write is done by reading the register first, then issuing the same address with the write flag set and the new value in the data field. The codec then echoes the address together with the newly written data.

Top module: `codec_cmd_seq`

## Requirements
- R1: After reset, `done_flag`, `slot_busy`, `stat_err`, `stat_addr` and `stat_data` are all 0.
- R2: A control word loaded with `ctl_we` mid-frame is held. `slot_busy` rises only on the clock edge that ends a cycle in which `frame_sync` was high.
- R3: `slot_busy` stays high for exactly `SLOT_LEN` cycles. During that time `slot_addr`, `slot_wflag` and `slot_data` hold the loaded command without change.
- R4: A read finishes on the edge that ends the slot. On that same edge `slot_busy` falls, `done_flag` sets, `stat_addr`/`stat_data` take the codec reply and `stat_err` is 0.
- R5: A command with `slot_wflag`=1 carries its 16-bit value in `slot_data`. Its completion reports the value now held by the codec register, and a later read of that address returns the same value.
- R6: `done_flag` stays set across any number of frames until a cycle with `done_clr`=1, after which it reads 0.
- R7: A reply whose echoed address differs from the sent address causes the command to be sent again in the next frame. `done_flag` stays low until a good reply arrives.
- R8: After `MAX_TRIES` (default 3) attempts with bad replies, the block sets `done_flag` with `stat_err`=1 and `stat_addr`/`stat_data` holding the last reply. It then sends nothing more.
- R9: A `ctl_we` pulse while `slot_busy` is high is ignored. The command in flight completes with its own address, and no extra command follows.
- R10: With no command loaded, frames pass with `slot_busy` low and `done_flag` unchanged.
- R11: `stat_addr`, `stat_data` and `stat_err` change only on the edge at which a command completes; attempts that are retried leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Load a control word (one-cycle pulse) |
| ctl_addr | input | AW | Codec register address |
| ctl_wflag | input | 1 | 1 = write, 0 = read |
| ctl_data | input | 16 | Write value |
| done_clr | input | 1 | Clear the completion flag |
| done_flag | output | 1 | Completion flag |
| stat_addr | output | AW | Echoed address of the completed command |
| stat_data | output | 16 | Returned data of the completed command |
| stat_err | output | 1 | 1 = all attempts returned a wrong address |
| frame_sync | output | 1 | High in the first cycle of each frame |
| slot_busy | output | 1 | Command slot in use this cycle |
| slot_addr | output | AW | Address sent in the slot |
| slot_wflag | output | 1 | Write flag sent in the slot |
| slot_data | output | 16 | Data sent in the slot |
| resp_addr | input | AW | Address echoed by the codec, sampled at slot end |
| resp_data | input | 16 | Data returned by the codec, sampled at slot end |

## Verification
The retry counter and the pending bit are internal state, and the ports show them within one frame. If the pending bit is lost, no slot starts at the next `frame_sync`. If the pending bit sticks, an extra slot appears in a frame where no command was loaded. If the retry count is wrong, the number of slots before `done_flag` rises is wrong, and this shows within at most `MAX_TRIES` frames. If the frame counter is off, the slot starts or ends on the wrong cycle. The bench checks every one of these cycle positions exactly.

// File: rtl/codec_cmd_seq.sv
module codec_cmd_seq #(
  parameter int AW        = 7,
  parameter int FRAME_LEN = 16,
  parameter int SLOT_LEN  = 4,
  parameter int MAX_TRIES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [AW-1:0] ctl_addr,
  input  logic          ctl_wflag,
  input  logic [15:0]   ctl_data,
  input  logic          done_clr,
  output logic          done_flag,
  output logic [AW-1:0] stat_addr,
  output logic [15:0]   stat_data,
  output logic          stat_err,
  output logic          frame_sync,
  output logic          slot_busy,
  output logic [AW-1:0] slot_addr,
  output logic          slot_wflag,
  output logic [15:0]   slot_data,
  input  logic [AW-1:0] resp_addr,
  input  logic [15:0]   resp_data
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam int TW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] cnt;
  logic [TW-1:0] tries;
  logic          pend;
  logic          slot_end, echo_ok, last_try, finish;

  assign frame_sync = (cnt == '0);
  assign slot_end   = slot_busy && (cnt == CW'(SLOT_LEN));
  assign echo_ok    = (resp_addr == slot_addr);
  assign last_try   = (tries == TW'(MAX_TRIES - 1));
  assign finish     = slot_end && (echo_ok || last_try);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == CW'(FRAME_LEN - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      tries      <= '0;
      slot_addr  <= '0;
      slot_wflag <= 1'b0;
      slot_data  <= '0;
    end else if (ctl_we && !slot_busy) begin
      pend       <= 1'b1;
      tries      <= '0;
      slot_addr  <= ctl_addr;
      slot_wflag <= ctl_wflag;
      slot_data  <= ctl_data;
    end else if (slot_end) begin
      if (finish) pend <= 1'b0;
      else        tries <= tries + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  slot_busy <= 1'b0;
    else if (slot_end)           slot_busy <= 1'b0;
    else if (frame_sync && pend) slot_busy <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      stat_addr <= '0;
      stat_data <= '0;
      stat_err  <= 1'b0;
    end else if (finish) begin
      done_flag <= 1'b1;
      stat_addr <= resp_addr;
      stat_data <= resp_data;
      stat_err  <= !echo_ok;
    end else if (done_clr) begin
      done_flag <= 1'b0;
    end
  end

  assert_launch_at_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_busy) |-> $past(frame_sync));
  assert_slot_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_busy && $past(slot_busy)) |-> ($stable(slot_addr) && $stable(slot_wflag) && $stable(slot_data)));
  assert_done_at_slot_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(slot_busy));
  assert_status_atomic_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({stat_addr, stat_data, stat_err}) |-> ($fell(slot_busy) && done_flag));
  assert_tries_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TW'(MAX_TRIES));
endmodule

// File: tb/codec_cmd_seq_test.sv
`timescale 1ns/1ps
module codec_cmd_seq_test;
  localparam int AW = 7, FL = 16, SL = 4, MT = 3;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_wflag = 0, done_clr = 0;
  logic [AW-1:0] ctl_addr = '0;
  logic [15:0] ctl_data = '0;
  logic done_flag, stat_err, frame_sync, slot_busy, slot_wflag;
  logic [AW-1:0] stat_addr, slot_addr, resp_addr;
  logic [15:0] stat_data, slot_data, resp_data;

  logic [15:0] mem [0:(1<<AW)-1];
  int bad_left = 0;
  int launches = 0;
  logic prev_busy = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  codec_cmd_seq #(.AW(AW), .FRAME_LEN(FL), .SLOT_LEN(SL), .MAX_TRIES(MT)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
    .ctl_wflag(ctl_wflag), .ctl_data(ctl_data), .done_clr(done_clr),
    .done_flag(done_flag), .stat_addr(stat_addr), .stat_data(stat_data),
    .stat_err(stat_err), .frame_sync(frame_sync), .slot_busy(slot_busy),
    .slot_addr(slot_addr), .slot_wflag(slot_wflag), .slot_data(slot_data),
    .resp_addr(resp_addr), .resp_data(resp_data));

  // codec model
  assign resp_addr = (bad_left > 0) ? (slot_addr ^ AW'(1)) : slot_addr;
  assign resp_data = slot_wflag ? slot_data : mem[slot_addr];

  always @(negedge clk) begin
    if (slot_busy && !prev_busy) launches = launches + 1;
    if (prev_busy && !slot_busy) begin
      if (bad_left > 0) bad_left = bad_left - 1;
      else if (slot_wflag) mem[slot_addr] = slot_data;
    end
    prev_busy = slot_busy;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_done();
    done_clr = 1; @(negedge clk); done_clr = 0;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic w, input logic [15:0] d);
    ctl_addr = a; ctl_wflag = w; ctl_data = d; ctl_we = 1;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wait_done(output int n_launch, output bit stat_moved);
    logic [31:0] s0;
    int l0;
    s0 = {stat_err, stat_addr, stat_data}; l0 = launches; stat_moved = 0;
    for (int i = 0; i < 100 * FL && !done_flag; i++) begin
      @(negedge clk);
      if (!done_flag && {stat_err, stat_addr, stat_data} != s0) stat_moved = 1;
    end
    n_launch = launches - l0;
  endtask

  task automatic t_reset();
    chk(done_flag == 0 && slot_busy == 0 && stat_err == 0, "R1 flags", {done_flag, slot_busy, stat_err}, 0);
    chk(stat_addr == 0 && stat_data == 0, "R1 status", {stat_addr, stat_data}, 0);
  endtask

  task automatic t_idle();
    int l0 = launches;
    bit busy_seen = 0;
    for (int i = 0; i < 3 * FL; i++) begin
      @(negedge clk);
      if (slot_busy || done_flag) busy_seen = 1;
    end
    chk(!busy_seen && launches == l0, "R10 idle frames", launches - l0, 0);
  endtask

  task automatic t_hold_read();
    bit stable = 1;
    while (!frame_sync) @(negedge clk);
    cyc(5);
    load(7'h12, 0, 16'hFFFF);
    cyc(10);
    chk(slot_busy == 0 && frame_sync == 1, "R2 held until frame start", {slot_busy, frame_sync}, 1);
    cyc(1);
    chk(slot_busy == 1, "R2 launch after frame_sync", slot_busy, 1);
    for (int i = 0; i < SL; i++) begin
      if (!slot_busy || slot_addr != 7'h12 || slot_wflag != 0 || slot_data != 16'hFFFF) stable = 0;
      if (i == SL - 1) chk(done_flag == 0, "R4 not done inside slot", done_flag, 0);
      if (i < SL - 1) @(negedge clk);
    end
    chk(stable, "R3 slot length and fields", stable, 1);
    cyc(1);
    chk(slot_busy == 0, "R3 slot ends", slot_busy, 0);
    chk(done_flag == 1 && stat_err == 0, "R4 done at slot end", {done_flag, stat_err}, 2);
    chk(stat_addr == 7'h12 && stat_data == mem[7'h12], "R4 read status", stat_data, mem[7'h12]);
  endtask

  task automatic t_clear();
    cyc(2 * FL);
    chk(done_flag == 1, "R6 flag held", done_flag, 1);
    clear_done();
    chk(done_flag == 0, "R6 flag cleared", done_flag, 0);
  endtask

  task automatic t_write();
    int n; bit mv;
    load(7'h33, 0, 16'h0);
    wait_done(n, mv);
    clear_done();
    load(7'h33, 1, 16'hBEEF);
    @(negedge clk);
    while (!slot_busy) @(negedge clk);
    chk(slot_wflag == 1 && slot_data == 16'hBEEF, "R5 write carried", slot_data, 16'hBEEF);
    wait_done(n, mv);
    chk(stat_addr == 7'h33 && stat_data == 16'hBEEF && !stat_err, "R5 write status", stat_data, 16'hBEEF);
    clear_done();
    load(7'h33, 0, 16'h0);
    wait_done(n, mv);
    chk(stat_data == 16'hBEEF, "R5 read back", stat_data, 16'hBEEF);
    clear_done();
  endtask

  task automatic t_retry();
    int n; bit mv;
    bad_left = 1;
    load(7'h05, 0, 16'h0);
    wait_done(n, mv);
    chk(n == 2, "R7 one resend", n, 2);
    chk(!stat_err && stat_addr == 7'h05 && stat_data == mem[7'h05], "R7 good after resend", stat_addr, 7'h05);
    chk(!mv, "R11 status still during retry", mv, 0);
    clear_done();
  endtask

  task automatic t_fail();
    int n, l0; bit mv;
    bad_left = 10;
    load(7'h08, 0, 16'h0);
    wait_done(n, mv);
    chk(n == MT, "R8 attempt count", n, MT);
    chk(stat_err == 1 && stat_addr == 7'h09 && stat_data == mem[7'h08], "R8 error status", {stat_err, stat_addr}, {1'b1, 7'h09});
    chk(!mv, "R11 status still during failing tries", mv, 0);
    l0 = launches;
    cyc(3 * FL);
    chk(launches == l0, "R8 nothing more sent", launches - l0, 0);
    bad_left = 0;
    clear_done();
  endtask

  task automatic t_ignore();
    int n, l0; bit mv;
    load(7'h21, 0, 16'h0);
    while (!slot_busy) @(negedge clk);
    load(7'h44, 1, 16'h1234);
    wait_done(n, mv);
    chk(stat_addr == 7'h21 && stat_data == mem[7'h21], "R9 in-flight kept", stat_addr, 7'h21);
    l0 = launches;
    cyc(3 * FL);
    chk(launches == l0 && mem[7'h44] != 16'h1234, "R9 no extra command", launches - l0, 0);
    clear_done();
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A00;
    cyc(3);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_hold_read();
    t_clear();
    t_write();
    t_retry();
    t_fail();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule